// File: doc/BRIEF.md
# Width-adaptive byte receive queue

This block is a byte-wide receive queue that a serial receive engine fills one byte at a time. On the other side is a bus-style read port. Each read request carries a width code that selects 8, 16 or 32 bits. A read takes one, two or four bytes from the head of the queue in a single access. It packs them into one return word, with the oldest byte in the lowest lane.

A write access aimed at the read port is a no-op. The queue keeps track of how many bytes it holds and drives empty and full indications. It also keeps two sticky error flags. Underflow is set when a read asks for more bytes than the queue holds. Overflow is set when a byte arrives while the queue is full.

A read request is applied for one clock cycle. Its data appears on `rd_data_o` after that clock edge and holds until the next read access. Requests may be issued on consecutive cycles.

Top module: `rxq_wide_rd`

## Requirements
- R1: After reset, `count_o` is 0, `empty_o` is 1, `full_o` is 0, both sticky flags are 0 and `rd_data_o` is 0. Asserting `rst_ni` low again returns to this state and clears both flags.
- R2: A read with `rd_width_i`=0 (8-bit) takes the oldest byte. It returns that byte in `rd_data_o[7:0]` with bits 31:8 zero, and lowers `count_o` by 1.
- R3: A read with `rd_width_i`=1 (16-bit) takes bytes b0 then b1. It returns {16'h0,b1,b0} and lowers `count_o` by 2.
- R4: A read with `rd_width_i`=2 or 3 (32-bit) takes b0..b3 in order. It returns {b3,b2,b1,b0} and lowers `count_o` by 4.
- R5: Read requests held on consecutive cycles, with the width changed every cycle, each return the correct next bytes in arrival order.
- R6: A request with `rd_write_i`=1 takes no bytes and leaves `rd_data_o` and `count_o` unchanged. A later read returns the bytes that were queued before it.
- R7: A read that needs more bytes than `count_o` takes nothing and returns 0. It sets `underflow_o`, which stays 1 until reset.
- R8: A push while `count_o` is 32 is dropped and sets `overflow_o`, which stays 1 until reset. The stored bytes are unchanged.
- R9: A push together with a successful read in the same cycle changes `count_o` by 1 minus the number of bytes read. The pushed byte lands behind the existing bytes.
- R10: `empty_o` is 1 exactly when `count_o` is 0, and `full_o` is 1 exactly when `count_o` is 32.
- R11: Byte order is kept when the storage pointers wrap past entry 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| push_valid_i | input | 1 | Byte arrives from the receive engine |
| push_data_i | input | 8 | Arriving byte |
| rd_req_i | input | 1 | Access to the read port this cycle |
| rd_write_i | input | 1 | Access is a write (ignored) |
| rd_width_i | input | 2 | 0: 8-bit, 1: 16-bit, 2/3: 32-bit |
| rd_data_o | output | 32 | Packed bytes of the last read access |
| count_o | output | 6 | Bytes held |
| empty_o | output | 1 | Queue holds no bytes |
| full_o | output | 1 | Queue holds 32 bytes |
| underflow_o | output | 1 | Sticky: short read seen |
| overflow_o | output | 1 | Sticky: push to full queue seen |

## Verification
The hardest case to reach from the ports is a multi-byte read whose bytes straddle the pointer wrap from entry 31 to entry 0. A second hard case is a push that lands in the same cycle as such a read.

To reach the wrap, the bench first advances the pointers with earlier traffic. It then fills the queue to 32 bytes, attempts one extra push, and drains the queue with 32-bit reads. These reads cross the wrap.

To cover the combined case, the bench keeps a byte-queue model that predicts the packed word and the new count. It then issues a push and a 32-bit read on the same clock edge and compares against the model.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned MAX_BYTES = 4;

  typedef enum logic [1:0] {
    RW_8  = 2'd0,
    RW_16 = 2'd1,
    RW_32 = 2'd2,
    RW_32B = 2'd3
  } rd_width_e;

  function automatic logic [2:0] bytes_for(input logic [1:0] w);
    case (w)
      RW_8:    bytes_for = 3'd1;
      RW_16:   bytes_for = 3'd2;
      default: bytes_for = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  logic [rxq_pkg::BYTE_W-1:0] wr_data_i,
  input  logic [2:0] pop_n_i,
  output logic [rxq_pkg::MAX_BYTES-1:0][rxq_pkg::BYTE_W-1:0] peek_o
);
  logic [rxq_pkg::BYTE_W-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_ptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (wr_en_i) wr_ptr_q <= wr_ptr_q + AW'(1);
      rd_ptr_q <= rd_ptr_q + AW'(pop_n_i);
    end
  end

  // head bytes, wrapping through the power-of-two pointer width
  for (genvar k = 0; k < rxq_pkg::MAX_BYTES; k++) begin : g_peek
    logic [AW-1:0] idx;
    assign idx       = rd_ptr_q + AW'(k);
    assign peek_o[k] = mem_q[idx];
  end
endmodule

// File: rtl/rxq_occ.sv
module rxq_occ #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic [2:0] dec_n_i,
  output logic [CW-1:0] count_o,
  output logic empty_o,
  output logic full_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + CW'(inc_i) - CW'(dec_n_i);
  end

  assign count_o = cnt_q;
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
endmodule

// File: rtl/rxq_wide_rd.sv
module rxq_wide_rd #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned CW = $clog2(DEPTH + 1),
  localparam int unsigned RD_W = rxq_pkg::BYTE_W * rxq_pkg::MAX_BYTES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic push_valid_i,
  input  logic [rxq_pkg::BYTE_W-1:0] push_data_i,
  input  logic rd_req_i,
  input  logic rd_write_i,
  input  logic [1:0] rd_width_i,
  output logic [RD_W-1:0] rd_data_o,
  output logic [CW-1:0] count_o,
  output logic empty_o,
  output logic full_o,
  output logic underflow_o,
  output logic overflow_o
);
  logic [2:0] need;
  logic rd_acc, short_rd, pop_ok, push_ok;
  logic [2:0] pop_n;
  logic [rxq_pkg::MAX_BYTES-1:0][rxq_pkg::BYTE_W-1:0] peek, lanes;
  logic [RD_W-1:0] rd_data_q;
  logic unf_q, ovf_q;

  assign need     = rxq_pkg::bytes_for(rd_width_i);
  assign rd_acc   = rd_req_i && !rd_write_i;
  assign short_rd = rd_acc && (CW'(need) > count_o);
  assign pop_ok   = rd_acc && !short_rd;
  assign pop_n    = pop_ok ? need : 3'd0;
  assign push_ok  = push_valid_i && !full_o;

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni,
    .wr_en_i  (push_ok),
    .wr_data_i(push_data_i),
    .pop_n_i  (pop_n),
    .peek_o   (peek)
  );

  rxq_occ #(.DEPTH(DEPTH)) u_occ (
    .clk_i, .rst_ni,
    .inc_i  (push_ok),
    .dec_n_i(pop_n),
    .count_o(count_o),
    .empty_o(empty_o),
    .full_o (full_o)
  );

  // lanes above the requested width read as zero
  for (genvar k = 0; k < rxq_pkg::MAX_BYTES; k++) begin : g_lane
    assign lanes[k] = (3'(k) < need) ? peek[k] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_q <= '0;
      unf_q     <= 1'b0;
      ovf_q     <= 1'b0;
    end else begin
      if (rd_acc) rd_data_q <= short_rd ? '0 : RD_W'(lanes);
      if (short_rd) unf_q <= 1'b1;
      if (push_valid_i && full_o) ovf_q <= 1'b1;
    end
  end

  assign rd_data_o   = rd_data_q;
  assign underflow_o = unf_q;
  assign overflow_o  = ovf_q;
endmodule

// File: rtl/rxq_wide_rd_chk.sv
module rxq_wide_rd_chk #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input logic clk_i,
  input logic rst_ni,
  input logic push_valid_i,
  input logic rd_req_i,
  input logic rd_write_i,
  input logic [1:0] rd_width_i,
  input logic [31:0] rd_data_o,
  input logic [CW-1:0] count_o,
  input logic empty_o,
  input logic full_o,
  input logic underflow_o,
  input logic overflow_o
);
  logic [CW-1:0] need_c;
  assign need_c = (rd_width_i == 2'd0) ? CW'(1) : (rd_width_i == 2'd1) ? CW'(2) : CW'(4);

  assert_count_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o <= CW'(DEPTH)) && !(empty_o && full_o));

  assert_underflow_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |=> underflow_o);

  assert_short_read_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && !rd_write_i && need_c > count_o && !push_valid_i)
    |=> (rd_data_o == 32'h0) && underflow_o && $stable(count_o));

  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_valid_i && !(rd_req_i && !rd_write_i)) |=> full_o && overflow_o);

  assert_overflow_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

  assert_write_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && rd_write_i && !push_valid_i) |=> $stable(count_o) && $stable(rd_data_o));

  assert_count_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && !rd_write_i && need_c <= count_o && push_valid_i && !full_o)
    |=> count_o == $past(count_o) + CW'(1) - $past(need_c));

  assert_upper_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && !rd_write_i && rd_width_i == 2'd0) |=> rd_data_o[31:8] == 24'h0);
endmodule

bind rxq_wide_rd rxq_wide_rd_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i, .rst_ni, .push_valid_i, .rd_req_i, .rd_write_i, .rd_width_i,
  .rd_data_o, .count_o, .empty_o, .full_o, .underflow_o, .overflow_o
);

// File: tb/rxq_wide_rd_tb.sv
`timescale 1ns/1ps
module rxq_wide_rd_tb;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic push_valid_i = 1'b0;
  logic [7:0] push_data_i = '0;
  logic rd_req_i = 1'b0;
  logic rd_write_i = 1'b0;
  logic [1:0] rd_width_i = '0;
  logic [31:0] rd_data_o;
  logic [5:0] count_o;
  logic empty_o, full_o, underflow_o, overflow_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] q [$];
  logic [7:0] nxt = 8'h10;
  logic exp_unf = 1'b0;
  logic exp_ovf = 1'b0;

  always #10 clk_i = ~clk_i;

  rxq_wide_rd u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req);
    chk(req, 32'(count_o), 32'(q.size()));
    chk(req, 32'(empty_o), 32'(q.size() == 0));
    chk(req, 32'(full_o), 32'(q.size() == 32));
    chk(req, 32'(underflow_o), 32'(exp_unf));
    chk(req, 32'(overflow_o), 32'(exp_ovf));
  endtask

  function automatic int nbytes(input logic [1:0] w);
    return (w == 2'd0) ? 1 : (w == 2'd1) ? 2 : 4;
  endfunction

  // model of one read access; drives nothing
  function automatic logic [31:0] model_read(input logic [1:0] w);
    logic [31:0] r = '0;
    int n = nbytes(w);
    if (n > q.size()) begin
      exp_unf = 1'b1;
      return 32'h0;
    end
    for (int k = 0; k < n; k++) r[8*k +: 8] = q.pop_front();
    return r;
  endfunction

  task automatic push_one(input logic [7:0] d);
    @(negedge clk_i);
    push_valid_i = 1'b1; push_data_i = d;
    if (q.size() < 32) q.push_back(d); else exp_ovf = 1'b1;
    @(negedge clk_i);
    push_valid_i = 1'b0;
  endtask

  task automatic push_n(input int n);
    for (int i = 0; i < n; i++) begin
      push_one(nxt);
      nxt = nxt + 8'd1;
    end
  endtask

  task automatic read_one(input string req, input logic [1:0] w);
    logic [31:0] e;
    @(negedge clk_i);
    rd_req_i = 1'b1; rd_write_i = 1'b0; rd_width_i = w;
    e = model_read(w);
    @(negedge clk_i);
    rd_req_i = 1'b0;
    chk(req, rd_data_o, e);
    chk_state(req);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    q.delete(); exp_unf = 1'b0; exp_ovf = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_reset();
    chk_state("R1 reset");
    chk("R1 reset data", rd_data_o, 32'h0);
  endtask

  task automatic t_widths();
    push_n(7);
    read_one("R2 8-bit", 2'd0);
    read_one("R3 16-bit", 2'd1);
    read_one("R4 32-bit", 2'd2);
    push_n(4);
    read_one("R4 32-bit code3", 2'd3);
  endtask

  task automatic t_burst();
    logic [31:0] e [3];
    logic [1:0] ws [3];
    ws[0] = 2'd1; ws[1] = 2'd0; ws[2] = 2'd2;
    push_n(7);
    @(negedge clk_i);
    rd_req_i = 1'b1; rd_write_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      rd_width_i = ws[i];
      e[i] = model_read(ws[i]);
      @(negedge clk_i);
      chk("R5 burst", rd_data_o, e[i]);
    end
    rd_req_i = 1'b0;
    chk_state("R5 burst end");
  endtask

  task automatic t_write_ignored();
    logic [31:0] prev;
    push_n(2);
    prev = rd_data_o;
    @(negedge clk_i);
    rd_req_i = 1'b1; rd_write_i = 1'b1; rd_width_i = 2'd2;
    @(negedge clk_i);
    rd_req_i = 1'b0; rd_write_i = 1'b0;
    chk("R6 write data", rd_data_o, prev);
    chk_state("R6 write count");
  endtask

  task automatic t_underflow();
    read_one("R7 short read", 2'd2);
    read_one("R7 after short", 2'd1);
    read_one("R7 empty 8-bit", 2'd0);
    push_n(1);
    read_one("R7 sticky", 2'd0);
  endtask

  task automatic t_overflow_wrap();
    push_n(32);
    chk_state("R10 full");
    push_one(8'hEE);
    chk_state("R8 overflow");
    for (int i = 0; i < 8; i++) read_one("R11 drain wrap", 2'd2);
    chk_state("R10 empty");
  endtask

  task automatic t_simul();
    logic [31:0] e;
    push_n(5);
    @(negedge clk_i);
    rd_req_i = 1'b1; rd_write_i = 1'b0; rd_width_i = 2'd2;
    push_valid_i = 1'b1; push_data_i = 8'hA5;
    e = model_read(2'd2);
    q.push_back(8'hA5);
    @(negedge clk_i);
    rd_req_i = 1'b0; push_valid_i = 1'b0;
    chk("R9 simul data", rd_data_o, e);
    chk_state("R9 simul count");
    read_one("R9 pushed byte order", 2'd1);
  endtask

  initial begin : watchdog
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_widths();
    t_burst();
    t_write_ignored();
    t_underflow();
    do_reset();
    t_reset();
    push_n(3);
    read_one("R11 offset", 2'd1);
    t_overflow_wrap();
    t_simul();
    do_reset();
    t_reset();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule